// File: doc/BRIEF.md
# Reset Sequencer with Cause Tracking

This block gathers every reset request of a small chip into a single active-low chip reset. It also records which kind of event produced the most recent reset. There are five requesters: a power-on pulse, a brown-out level that only counts when its enable is set, an active-low external reset pin, a watchdog time-out, and a sleep flag that tells run-time events apart from sleep-time ones. The external pin is passed through a glitch filter first, so that short noise pulses never reach the chip. When a sleep-time watchdog expiry is configured as a wake-up, it produces a wake pulse and is not treated as a reset.

Once every request has gone away, the chip reset is still held until the enabled start-up delays have finished. One delay counter runs on the main oscillator clock. The other runs on a slow, free-running RC clock. Each delay can be bypassed on its own. Reset assertion is asynchronous. Release passes through a two-flop synchronizer on the oscillator clock.

Two software-visible status bits, time-out and power-down, are loaded according to the reset kind. Software can also write them. A 3-bit cause code names the last reset.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_i` is high, `chip_rst_n_o` is 0, `cause_o` is 1 and both `to_o` and `pd_o` are 1. With both delays bypassed, `chip_rst_n_o` rises right after the 4th rising `osc_clk` edge that samples `por_i` low.
- R2: While `bod_en_i` is 1, a high `bod_i` drives `chip_rst_n_o` low with no clock edge needed, sets `cause_o` to 2, and sets `to_o`=1 and `pd_o`=1. While `bod_en_i` is 0, `bod_i` has no effect on the outputs.
- R3: A watchdog time-out sampled while `sleep_i` is 0 asserts reset, sets `cause_o` to 3, clears `to_o` and sets `pd_o`.
- R4: A watchdog time-out sampled while `sleep_i` is 1 and `wake_en_i` is 0 asserts reset, sets `cause_o` to 4, and clears both `to_o` and `pd_o`.
- R5: A watchdog time-out sampled while `sleep_i` is 1 and `wake_en_i` is 1 gives a one-cycle pulse on `wake_o`. It causes no reset and leaves `to_o`, `pd_o` and `cause_o` unchanged.
- R6: A low on `ext_rst_n_i` that lasts fewer than FILT_LEN (default 4) `osc_clk` cycles is ignored. A low that lasts FILT_LEN cycles or longer asserts reset.
- R7: A filtered pin reset sets `cause_o` to 5, or to 6 when `sleep_i` is 1 at detection, and leaves `to_o` and `pd_o` unchanged.
- R8: When the power-up delay is bypassed, let E be the first `osc_clk` edge that samples no request. `chip_rst_n_o` rises right after edge E+D+2, where D is 2^OST_W with `ost_en_i`=1 and 1 with `ost_en_i`=0.
- R9: With `pwrt_en_i`=1, release waits at least 2^PWRT_W−1 `rc_clk` periods after the requests end.
- R10: A high `sw_we_i` loads `sw_to_i` and `sw_pd_i` into `to_o` and `pd_o` on the next edge. A reset event sampled in the same cycle wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Main oscillator clock, also the system clock |
| rc_clk | input | 1 | Slow internal RC clock for the power-up delay |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| bod_i | input | 1 | Brown-out detect level, active high |
| bod_en_i | input | 1 | Enables brown-out as a reset source |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdt_to_i | input | 1 | Watchdog time-out, one-cycle pulse on osc_clk |
| sleep_i | input | 1 | Core is in sleep |
| wake_en_i | input | 1 | Sleep-time watchdog expiry wakes instead of resetting |
| ost_en_i | input | 1 | Enables the oscillator start-up delay |
| pwrt_en_i | input | 1 | Enables the RC power-up delay |
| sw_we_i | input | 1 | Software write strobe for the status bits |
| sw_to_i | input | 1 | Value written to the time-out bit |
| sw_pd_i | input | 1 | Value written to the power-down bit |
| chip_rst_n_o | output | 1 | Chip reset, active low |
| to_o | output | 1 | Time-out status bit |
| pd_o | output | 1 | Power-down status bit |
| cause_o | output | 3 | Last reset cause (1 power-on, 2 brown-out, 3/4 watchdog run/sleep, 5/6 pin run/sleep) |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The properties take `por_i` as the checker's own reset, and they expect `wdt_to_i`, `sleep_i`, `wake_en_i` and `sw_we_i` to change only away from the rising `osc_clk` edge. They also expect a brown-out request to stay high across at least one oscillator edge. The stimulus drives every input on the falling edge. It raises `por_i` only after time zero, and it holds brown-out requests for several cycles. Pin pulses are also driven on falling edges, with their widths swept from 1 to 6 cycles.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE      = 3'd0,
    CAUSE_POR       = 3'd1,
    CAUSE_BOD       = 3'd2,
    CAUSE_WDT_RUN   = 3'd3,
    CAUSE_WDT_SLEEP = 3'd4,
    CAUSE_PIN_RUN   = 3'd5,
    CAUSE_PIN_SLEEP = 3'd6
  } cause_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HOLD = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_e;
endpackage

// File: rtl/rstseq_sync2.sv
module rstseq_sync2 #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic stage1;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rstseq_pin_filter.sv
module rstseq_pin_filter #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic arst,
  input  logic pin_n,
  output logic trip
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LIM = CW'(LEN);

  logic pin_s;
  logic [CW-1:0] low_cnt;

  rstseq_sync2 #(.RST_VAL(1'b1)) u_pin_sync (
    .clk (clk),
    .arst(arst),
    .d   (pin_n),
    .q   (pin_s)
  );

  // count consecutive low samples, saturate at the limit
  always_ff @(posedge clk or posedge arst) begin
    if (arst)                low_cnt <= '0;
    else if (pin_s)          low_cnt <= '0;
    else if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
  end

  assign trip = (low_cnt == LIM);
endmodule

// File: rtl/rstseq_delay_cnt.sv
module rstseq_delay_cnt #(
  parameter int unsigned W = 10
) (
  input  logic clk,
  input  logic arst,
  input  logic run,
  output logic done
);
  logic [W-1:0] cnt;

  assign done = &cnt;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)       cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int unsigned OST_W    = 10,
  parameter int unsigned PWRT_W   = 10,
  parameter int unsigned FILT_LEN = 4
) (
  input  logic       osc_clk,
  input  logic       rc_clk,
  input  logic       por_i,
  input  logic       bod_i,
  input  logic       bod_en_i,
  input  logic       ext_rst_n_i,
  input  logic       wdt_to_i,
  input  logic       sleep_i,
  input  logic       wake_en_i,
  input  logic       ost_en_i,
  input  logic       pwrt_en_i,
  input  logic       sw_we_i,
  input  logic       sw_to_i,
  input  logic       sw_pd_i,
  output logic       chip_rst_n_o,
  output logic       to_o,
  output logic       pd_o,
  output logic [2:0] cause_o,
  output logic       wake_o
);
  logic   bod_act, kill;
  logic   pin_trip, pin_trip_q, pin_new;
  logic   wdt_wake, wdt_src, src_any;
  logic   ost_done, ost_run, ost_ok;
  logic   rc_req, rc_run, rc_done, rc_done_s, rc_ok;
  logic   out_clr;
  seq_e   state_q, state_d;
  cause_e cause_q;
  logic   to_q, pd_q, wake_q;

  assign bod_act  = bod_i & bod_en_i;
  assign kill     = por_i | bod_act;
  assign wdt_wake = wdt_to_i & sleep_i & wake_en_i;
  assign wdt_src  = wdt_to_i & ~(sleep_i & wake_en_i);
  assign pin_new  = pin_trip & ~pin_trip_q;
  assign src_any  = bod_act | wdt_src | pin_trip;

  rstseq_pin_filter #(.LEN(FILT_LEN)) u_filter (
    .clk  (osc_clk),
    .arst (por_i),
    .pin_n(ext_rst_n_i),
    .trip (pin_trip)
  );

  // start-up delay on the oscillator clock
  assign ost_run = (state_q == SEQ_WAIT) && ost_en_i;
  rstseq_delay_cnt #(.W(OST_W)) u_ost (
    .clk (osc_clk),
    .arst(kill),
    .run (ost_run),
    .done(ost_done)
  );

  // power-up delay on the RC clock, request and done cross domains
  assign rc_req = (state_q == SEQ_WAIT) && pwrt_en_i;
  rstseq_sync2 #(.RST_VAL(1'b0)) u_req_sync (
    .clk (rc_clk),
    .arst(por_i),
    .d   (rc_req),
    .q   (rc_run)
  );
  rstseq_delay_cnt #(.W(PWRT_W)) u_pwrt (
    .clk (rc_clk),
    .arst(por_i),
    .run (rc_run),
    .done(rc_done)
  );
  rstseq_sync2 #(.RST_VAL(1'b0)) u_done_sync (
    .clk (osc_clk),
    .arst(por_i),
    .d   (rc_done),
    .q   (rc_done_s)
  );

  assign ost_ok = ~ost_en_i | ost_done;
  assign rc_ok  = ~pwrt_en_i | rc_done_s;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (src_any) state_d = SEQ_HOLD;
      // a stale done from an earlier run must clear before counting
      SEQ_HOLD: if (!src_any && (!pwrt_en_i || !rc_done_s)) state_d = SEQ_WAIT;
      SEQ_WAIT: begin
        if (src_any)              state_d = SEQ_HOLD;
        else if (ost_ok && rc_ok) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_HOLD;
    endcase
  end

  always_ff @(posedge osc_clk or posedge kill) begin
    if (kill) state_q <= SEQ_HOLD;
    else      state_q <= state_d;
  end

  // assertion is asynchronous, release walks through two flops
  assign out_clr = kill | (state_q != SEQ_IDLE);
  rstseq_sync2 #(.RST_VAL(1'b0)) u_out_sync (
    .clk (osc_clk),
    .arst(out_clr),
    .d   (1'b1),
    .q   (chip_rst_n_o)
  );

  always_ff @(posedge osc_clk or posedge por_i) begin
    if (por_i) begin
      cause_q    <= CAUSE_POR;
      to_q       <= 1'b1;
      pd_q       <= 1'b1;
      wake_q     <= 1'b0;
      pin_trip_q <= 1'b0;
    end else begin
      pin_trip_q <= pin_trip;
      wake_q     <= wdt_wake & ~bod_act;
      if (bod_act) begin
        cause_q <= CAUSE_BOD;
        to_q    <= 1'b1;
        pd_q    <= 1'b1;
      end else if (wdt_src) begin
        cause_q <= sleep_i ? CAUSE_WDT_SLEEP : CAUSE_WDT_RUN;
        to_q    <= 1'b0;
        pd_q    <= ~sleep_i;
      end else if (pin_new) begin
        cause_q <= sleep_i ? CAUSE_PIN_SLEEP : CAUSE_PIN_RUN;
      end else if (sw_we_i) begin
        to_q <= sw_to_i;
        pd_q <= sw_pd_i;
      end
    end
  end

  assign to_o    = to_q;
  assign pd_o    = pd_q;
  assign cause_o = cause_q;
  assign wake_o  = wake_q;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
  input logic       osc_clk,
  input logic       por_i,
  input logic       bod_i,
  input logic       bod_en_i,
  input logic       wdt_to_i,
  input logic       sleep_i,
  input logic       wake_en_i,
  input logic       sw_we_i,
  input logic       chip_rst_n_o,
  input logic       to_o,
  input logic       pd_o,
  input logic [2:0] cause_o,
  input logic       wake_o
);
  logic bod_act;
  assign bod_act = bod_i & bod_en_i;

  always @(posedge osc_clk) begin
    if (por_i) begin
      assert_por_state_R1: assert (!chip_rst_n_o && cause_o == 3'd1 && to_o && pd_o);
    end
  end

  assert_bod_holds_R2: assert property (@(posedge osc_clk) disable iff (por_i)
    bod_act |-> !chip_rst_n_o);

  assert_wdt_run_R3: assert property (@(posedge osc_clk) disable iff (por_i)
    (wdt_to_i && !sleep_i && !bod_act) |=> (!chip_rst_n_o && !to_o && pd_o && cause_o == 3'd3));

  assert_wdt_sleep_R4: assert property (@(posedge osc_clk) disable iff (por_i)
    (wdt_to_i && sleep_i && !wake_en_i && !bod_act) |=> (!chip_rst_n_o && !to_o && !pd_o && cause_o == 3'd4));

  assert_wake_quiet_R5: assert property (@(posedge osc_clk) disable iff (por_i)
    (wdt_to_i && sleep_i && wake_en_i && !bod_act && !sw_we_i) |=> (wake_o && $stable(to_o) && $stable(pd_o) && $stable(cause_o)));

  assert_clean_release_R8: assert property (@(posedge osc_clk) disable iff (por_i)
    $rose(chip_rst_n_o) |-> (!bod_act && cause_o != 3'd0));
endmodule

bind reset_sequencer rstseq_chk u_chk (
  .osc_clk     (osc_clk),
  .por_i       (por_i),
  .bod_i       (bod_i),
  .bod_en_i    (bod_en_i),
  .wdt_to_i    (wdt_to_i),
  .sleep_i     (sleep_i),
  .wake_en_i   (wake_en_i),
  .sw_we_i     (sw_we_i),
  .chip_rst_n_o(chip_rst_n_o),
  .to_o        (to_o),
  .pd_o        (pd_o),
  .cause_o     (cause_o),
  .wake_o      (wake_o)
);

// File: tb/tb_reset_sequencer.sv
`timescale 1ns/1ps
module tb_reset_sequencer;
  localparam int OST_W  = 4;
  localparam int PWRT_W = 3;
  localparam int FILT   = 4;

  logic osc_clk = 1'b0, rc_clk = 1'b0;
  logic por_i = 1'b0, bod_i = 1'b0, bod_en_i = 1'b0, ext_rst_n_i = 1'b1;
  logic wdt_to_i = 1'b0, sleep_i = 1'b0, wake_en_i = 1'b0;
  logic ost_en_i = 1'b0, pwrt_en_i = 1'b0;
  logic sw_we_i = 1'b0, sw_to_i = 1'b0, sw_pd_i = 1'b0;
  logic chip_rst_n_o, to_o, pd_o, wake_o;
  logic [2:0] cause_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 osc_clk = ~osc_clk;
  always #10  rc_clk  = ~rc_clk;

  reset_sequencer #(.OST_W(OST_W), .PWRT_W(PWRT_W), .FILT_LEN(FILT)) dut (
    .osc_clk(osc_clk), .rc_clk(rc_clk), .por_i(por_i), .bod_i(bod_i),
    .bod_en_i(bod_en_i), .ext_rst_n_i(ext_rst_n_i), .wdt_to_i(wdt_to_i),
    .sleep_i(sleep_i), .wake_en_i(wake_en_i), .ost_en_i(ost_en_i),
    .pwrt_en_i(pwrt_en_i), .sw_we_i(sw_we_i), .sw_to_i(sw_to_i),
    .sw_pd_i(sw_pd_i), .chip_rst_n_o(chip_rst_n_o), .to_o(to_o),
    .pd_o(pd_o), .cause_o(cause_o), .wake_o(wake_o)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_range(string req, string what, int act, int lo, int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic check_status(string req, int cause, int to, int pd);
    check_eq(req, "cause", int'(cause_o), cause);
    check_eq(req, "to/pd", int'({to_o, pd_o}), (to << 1) | pd);
  endtask

  task automatic wait_release(output int k);
    k = 0;
    while (!chip_rst_n_o && k < 400) begin
      @(posedge osc_clk);
      @(negedge osc_clk);
      k++;
    end
  endtask

  task automatic sw_set(bit t, bit p);
    @(negedge osc_clk);
    sw_we_i = 1'b1; sw_to_i = t; sw_pd_i = p;
    @(negedge osc_clk);
    sw_we_i = 1'b0;
  endtask

  task automatic fire_wdt(output int k);
    @(negedge osc_clk);
    wdt_to_i = 1'b1;
    @(negedge osc_clk);
    wdt_to_i = 1'b0;
    wait_release(k);
  endtask

  task automatic pin_try(int w, bit slp, output bit tripped);
    @(negedge osc_clk);
    sleep_i = slp;
    ext_rst_n_i = 1'b0;
    repeat (w) @(negedge osc_clk);
    ext_rst_n_i = 1'b1;
    tripped = 1'b0;
    repeat (10) begin
      @(negedge osc_clk);
      if (!chip_rst_n_o) tripped = 1'b1;
    end
    sleep_i = 1'b0;
  endtask

  initial begin
    int k;
    bit tr;
    int last_cause;

    // R1: power-on
    #1 por_i = 1'b1;
    repeat (5) @(negedge osc_clk);
    check_eq("R1", "rst during por", int'(chip_rst_n_o), 0);
    check_status("R1", 1, 1, 1);
    por_i = 1'b0;
    wait_release(k);
    check_eq("R1", "por release edges", k, 4);
    check_status("R1", 1, 1, 1);

    // R10: software write
    sw_set(1'b0, 1'b0);
    check_eq("R10", "to/pd after write", int'({to_o, pd_o}), 0);
    sw_set(1'b1, 1'b0);
    check_eq("R10", "to/pd after write", int'({to_o, pd_o}), 2);

    // R3 and R8: run-time watchdog, with the start-up delay off and on
    for (int ost = 0; ost < 2; ost++) begin
      ost_en_i = ost[0];
      sw_set(1'b1, 1'b0);
      fire_wdt(k);
      check_eq("R8", "release edges", k, (ost != 0 ? (1 << OST_W) : 1) + 3);
      check_status("R3", 3, 0, 1);
    end
    ost_en_i = 1'b0;

    // R4: sleep-time watchdog without wake
    sw_set(1'b1, 1'b1);
    @(negedge osc_clk);
    sleep_i = 1'b1;
    fire_wdt(k);
    sleep_i = 1'b0;
    check_eq("R4", "release edges", k, 4);
    check_status("R4", 4, 0, 0);

    // R5: sleep-time watchdog configured as wake-up
    sw_set(1'b1, 1'b0);
    @(negedge osc_clk);
    sleep_i = 1'b1; wake_en_i = 1'b1; wdt_to_i = 1'b1;
    @(negedge osc_clk);
    wdt_to_i = 1'b0;
    check_eq("R5", "wake pulse", int'(wake_o), 1);
    begin
      bit dropped = 1'b0;
      @(negedge osc_clk);
      check_eq("R5", "wake pulse width", int'(wake_o), 0);
      repeat (10) begin
        @(negedge osc_clk);
        if (!chip_rst_n_o) dropped = 1'b1;
      end
      check_eq("R5", "no reset on wake", int'(dropped), 0);
    end
    check_status("R5", 4, 1, 0);
    sleep_i = 1'b0; wake_en_i = 1'b0;

    // R6 and R7: pin width sweep
    last_cause = 4;
    for (int w = 1; w <= 6; w++) begin
      sw_set(1'b0, 1'b1);
      pin_try(w, 1'b0, tr);
      check_eq("R6", $sformatf("pin width %0d trips", w), int'(tr), (w >= FILT) ? 1 : 0);
      wait_release(k);
      if (w >= FILT) last_cause = 5;
      check_status("R7", last_cause, 0, 1);
    end
    sw_set(1'b1, 1'b1);
    pin_try(5, 1'b1, tr);
    check_eq("R6", "sleep pin trips", int'(tr), 1);
    wait_release(k);
    check_status("R7", 6, 1, 1);

    // R2: brown-out, disabled then enabled
    sw_set(1'b0, 1'b0);
    @(negedge osc_clk);
    bod_i = 1'b1;
    begin
      bit dropped = 1'b0;
      repeat (6) begin
        @(negedge osc_clk);
        if (!chip_rst_n_o) dropped = 1'b1;
      end
      check_eq("R2", "disabled brown-out ignored", int'(dropped), 0);
    end
    bod_i = 1'b0;
    check_status("R2", 6, 0, 0);
    @(negedge osc_clk);
    bod_en_i = 1'b1;
    #0.5 bod_i = 1'b1;
    #0.5;
    check_eq("R2", "async assert", int'(chip_rst_n_o), 0);
    repeat (5) @(negedge osc_clk);
    bod_i = 1'b0;
    wait_release(k);
    check_eq("R2", "release edges", k, 4);
    check_status("R2", 2, 1, 1);
    bod_en_i = 1'b0;

    // R9: RC power-up delay, alone and with the start-up delay
    for (int both = 0; both < 2; both++) begin
      pwrt_en_i = 1'b1;
      ost_en_i = both[0];
      fire_wdt(k);
      check_range("R9", "rc release edges", k, ((1 << PWRT_W) - 1) * 4, ((1 << PWRT_W) + 3) * 4 + 8);
    end
    pwrt_en_i = 1'b0; ost_en_i = 1'b0;

    // R10: a reset event beats a same-cycle write
    @(negedge osc_clk);
    wdt_to_i = 1'b1; sw_we_i = 1'b1; sw_to_i = 1'b1; sw_pd_i = 1'b0;
    @(negedge osc_clk);
    wdt_to_i = 1'b0; sw_we_i = 1'b0;
    check_status("R10", 3, 0, 1);
    wait_release(k);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule